// File: doc/BRIEF.md
# Configuration Request Routing Decoder

This block takes one configuration access request, given as bus, device, function and register numbers plus a read/write flag, and decides which target receives it. On bus 0 a small set of internal devices can claim the request when enabled. A non-zero bus number can be claimed by one of several bridges, each of which owns an inclusive bus window. Anything left over is forwarded subtractively onto a downstream link, either as a Type 0 packet (bus 0) or a Type 1 packet (other buses). A request that no target claims ends as a master abort.

The decision is made by a two-state machine. In `ST_IDLE` the block waits; the *accept* transition to `ST_DONE` happens on a clock edge where `req_valid` is high, and the decision and the request header are captured at that edge. In `ST_DONE` the block shows the decision for exactly one cycle together with `done`, then takes the *retire* transition back to `ST_IDLE` unconditionally. Requests offered while in `ST_DONE` are not accepted.

Top module: `cfg_route_decoder`

## Requirements
- R1: After reset `done` is low and `route` is all zeros.
- R2: A request sampled with `req_valid` high in `ST_IDLE` makes `done` high for exactly the one cycle after that edge, with exactly one `route` bit set; otherwise `route` is zero. With the default sizes the route bits are: bit 0 internal device 0, bit 1 internal device 1, bit 2 bridge 0, bit 3 bridge 1, bit 4 downstream link, bit 5 master abort.
- R3: A request offered while `done` is high is ignored: no `done` follows it and the captured header outputs keep the previous request.
- R4: On bus 0, device d below `NUM_LOCAL` (default 2) is claimed on route bit d when `loc_dev_en[d]` is 1 and the function number is below `LOCAL_FUNCS` (default 1, so function 0 only); `pkt_type1` is then 0.
- R5: A bus 0 request that is not claimed internally (device 2 to 31, enable bit clear, or unimplemented function) goes to the downstream link when `link_dev_present[device]` is 1, with `pkt_type1` = 0 (Type 0).
- R6: A non-zero bus number with secondary <= bus <= subordinate of a bridge goes to that bridge; `pkt_type1` is 0 when the bus equals the secondary bus number and 1 otherwise. Bus 0 never matches a bridge.
- R7: When several bridge windows match, the lowest-numbered bridge is chosen.
- R8: A bridge (or link) window whose subordinate number is below its secondary number matches no bus.
- R9: A non-zero bus matched by no bridge but inside the link window [`link_sec_bus`, `link_sub_bus`] goes to the downstream link with `pkt_type1` = 1 (Type 1).
- R10: A request matched by none of the above selects the master abort route, with `pkt_type1` = 0.
- R11: On a master-abort read `abort_rdata` is all ones during `done`, otherwise it is zero; `wr_pass` is high during `done` only for a write that does not abort, so abort write data is dropped.
- R12: `out_bus`, `out_dev`, `out_func`, `out_reg` and `out_write` hold the fields of the last accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted in `ST_IDLE` |
| req_bus | input | 8 | Requested bus number |
| req_dev | input | 5 | Requested device number |
| req_func | input | 3 | Requested function number |
| req_reg | input | 8 | Requested register number |
| req_write | input | 1 | 1 for write, 0 for read |
| loc_dev_en | input | NUM_LOCAL | Enable bit per internal device |
| link_dev_present | input | 32 | Bus 0 devices present behind the downstream link |
| link_sec_bus | input | 8 | Lowest bus reached through the link |
| link_sub_bus | input | 8 | Highest bus reached through the link |
| br_sec_bus | input | NUM_BRIDGES*8 | Secondary bus number per bridge, bridge 0 in the low byte |
| br_sub_bus | input | NUM_BRIDGES*8 | Subordinate bus number per bridge, bridge 0 in the low byte |
| done | output | 1 | One-cycle decision pulse |
| route | output | NUM_LOCAL+NUM_BRIDGES+2 | One-hot target selection during `done` |
| pkt_type1 | output | 1 | 1 for Type 1, 0 for Type 0 packet |
| abort_rdata | output | 32 | All-ones fill for an aborted read |
| wr_pass | output | 1 | Write data may be delivered |
| out_bus | output | 8 | Captured bus number |
| out_dev | output | 5 | Captured device number |
| out_func | output | 3 | Captured function number |
| out_reg | output | 8 | Captured register number |
| out_write | output | 1 | Captured read/write flag |

## Verification
Every device and function number on bus 0 is swept under four combinations of internal enables and link-present masks, which separates an internal claim from Type 0 forwarding and from an abort, and shows that the function number alone can turn a claim into forwarding. Every bus number from 0 to 255 is then swept under four bridge and link layouts: disjoint windows, overlapping windows (priority), a reversed bridge window and a reversed link window, telling bridge claims, Type 0 versus Type 1 at the secondary bus, Type 1 link forwarding and aborts apart at each window edge. A request offered during the decision cycle is checked to be dropped, and read/write alternation shows the abort fill and write blocking.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned DEV_W  = 5;
    localparam int unsigned FUNC_W = 3;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned DATA_W = 32;

    typedef logic [BUS_W-1:0] bus_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } dec_state_e;

    // inclusive window; a reversed window claims nothing
    function automatic logic window_hit(bus_t bus, bus_t lo, bus_t hi);
        return (hi >= lo) && (bus >= lo) && (bus <= hi);
    endfunction
endpackage

// File: rtl/cfg_local_claim.sv
module cfg_local_claim
    import cfg_route_pkg::*;
#(
    parameter int unsigned NUM_LOCAL   = 2,
    parameter int unsigned LOCAL_FUNCS = 1
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUNC_W-1:0] func,
    input  logic [NUM_LOCAL-1:0] dev_en,
    output logic [NUM_LOCAL-1:0] claim
);
    logic on_root;
    logic func_ok;

    assign on_root = (bus == '0);
    assign func_ok = (int'(func) < int'(LOCAL_FUNCS));

    for (genvar d = 0; d < NUM_LOCAL; d++) begin : g_dev
        assign claim[d] = on_root && func_ok && dev_en[d] && (dev == DEV_W'(d));
    end
endmodule

// File: rtl/cfg_bridge_select.sv
module cfg_bridge_select
    import cfg_route_pkg::*;
#(
    parameter int unsigned NUM_BRIDGES = 2
) (
    input  logic [BUS_W-1:0]             bus,
    input  logic [NUM_BRIDGES*BUS_W-1:0] sec_flat,
    input  logic [NUM_BRIDGES*BUS_W-1:0] sub_flat,
    output logic                         any_hit,
    output logic [NUM_BRIDGES-1:0]       sel,
    output logic                         type1
);
    logic [NUM_BRIDGES-1:0] raw;
    logic [NUM_BRIDGES-1:0] below_sec;

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_win
        bus_t lo;
        bus_t hi;
        assign lo = sec_flat[b*BUS_W +: BUS_W];
        assign hi = sub_flat[b*BUS_W +: BUS_W];
        assign raw[b]       = (bus != '0) && window_hit(bus, lo, hi);
        assign below_sec[b] = (bus != lo);
    end

    // lowest set bit wins
    assign sel     = raw & (~raw + NUM_BRIDGES'(1));
    assign any_hit = |raw;
    assign type1   = |(sel & below_sec);
endmodule

// File: rtl/cfg_link_select.sv
module cfg_link_select
    import cfg_route_pkg::*;
(
    input  logic [BUS_W-1:0]       bus,
    input  logic [DEV_W-1:0]       dev,
    input  logic [(1<<DEV_W)-1:0]  dev_present,
    input  logic [BUS_W-1:0]       link_lo,
    input  logic [BUS_W-1:0]       link_hi,
    output logic                   hit,
    output logic                   type1
);
    logic on_root;

    assign on_root = (bus == '0);
    assign hit     = on_root ? dev_present[dev] : window_hit(bus, link_lo, link_hi);
    assign type1   = !on_root;
endmodule

// File: rtl/cfg_route_decoder.sv
module cfg_route_decoder
    import cfg_route_pkg::*;
#(
    parameter int unsigned NUM_LOCAL   = 2,
    parameter int unsigned LOCAL_FUNCS = 1,
    parameter int unsigned NUM_BRIDGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [BUS_W-1:0]               req_bus,
    input  logic [DEV_W-1:0]               req_dev,
    input  logic [FUNC_W-1:0]              req_func,
    input  logic [REG_W-1:0]               req_reg,
    input  logic                           req_write,
    input  logic [NUM_LOCAL-1:0]           loc_dev_en,
    input  logic [(1<<DEV_W)-1:0]          link_dev_present,
    input  logic [BUS_W-1:0]               link_sec_bus,
    input  logic [BUS_W-1:0]               link_sub_bus,
    input  logic [NUM_BRIDGES*BUS_W-1:0]   br_sec_bus,
    input  logic [NUM_BRIDGES*BUS_W-1:0]   br_sub_bus,
    output logic                           done,
    output logic [NUM_LOCAL+NUM_BRIDGES+1:0] route,
    output logic                           pkt_type1,
    output logic [DATA_W-1:0]              abort_rdata,
    output logic                           wr_pass,
    output logic [BUS_W-1:0]               out_bus,
    output logic [DEV_W-1:0]               out_dev,
    output logic [FUNC_W-1:0]              out_func,
    output logic [REG_W-1:0]               out_reg,
    output logic                           out_write
);
    localparam int unsigned BR_BASE    = NUM_LOCAL;
    localparam int unsigned LINK_IDX   = NUM_LOCAL + NUM_BRIDGES;
    localparam int unsigned ABORT_IDX  = LINK_IDX + 1;
    localparam int unsigned NUM_ROUTES = ABORT_IDX + 1;

    dec_state_e state_q, state_nx;

    logic [NUM_LOCAL-1:0]   loc_claim;
    logic                   br_hit;
    logic [NUM_BRIDGES-1:0] br_sel;
    logic                   br_t1;
    logic                   lk_hit;
    logic                   lk_t1;

    logic [NUM_ROUTES-1:0]  route_nx, route_q;
    logic                   t1_nx, t1_q;
    logic [BUS_W-1:0]       bus_q;
    logic [DEV_W-1:0]       dev_q;
    logic [FUNC_W-1:0]      func_q;
    logic [REG_W-1:0]       reg_q;
    logic                   wr_q;

    cfg_local_claim #(
        .NUM_LOCAL   (NUM_LOCAL),
        .LOCAL_FUNCS (LOCAL_FUNCS)
    ) u_local (
        .bus    (req_bus),
        .dev    (req_dev),
        .func   (req_func),
        .dev_en (loc_dev_en),
        .claim  (loc_claim)
    );

    cfg_bridge_select #(
        .NUM_BRIDGES (NUM_BRIDGES)
    ) u_bridge (
        .bus      (req_bus),
        .sec_flat (br_sec_bus),
        .sub_flat (br_sub_bus),
        .any_hit  (br_hit),
        .sel      (br_sel),
        .type1    (br_t1)
    );

    cfg_link_select u_link (
        .bus         (req_bus),
        .dev         (req_dev),
        .dev_present (link_dev_present),
        .link_lo     (link_sec_bus),
        .link_hi     (link_sub_bus),
        .hit         (lk_hit),
        .type1       (lk_t1)
    );

    // priority: internal claim, bridge window, link, abort
    always_comb begin
        route_nx = '0;
        t1_nx    = 1'b0;
        if (|loc_claim) begin
            route_nx[NUM_LOCAL-1:0] = loc_claim;
        end else if (br_hit) begin
            route_nx[LINK_IDX-1:BR_BASE] = br_sel;
            t1_nx = br_t1;
        end else if (lk_hit) begin
            route_nx[LINK_IDX] = 1'b1;
            t1_nx = lk_t1;
        end else begin
            route_nx[ABORT_IDX] = 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = req_valid ? ST_DONE : ST_IDLE;  // accept
            ST_DONE: state_nx = ST_IDLE;                        // retire
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            route_q <= '0;
            t1_q    <= 1'b0;
            bus_q   <= '0;
            dev_q   <= '0;
            func_q  <= '0;
            reg_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE && req_valid) begin
                route_q <= route_nx;
                t1_q    <= t1_nx;
                bus_q   <= req_bus;
                dev_q   <= req_dev;
                func_q  <= req_func;
                reg_q   <= req_reg;
                wr_q    <= req_write;
            end
        end
    end

    always_comb begin
        done        = (state_q == ST_DONE);
        route       = done ? route_q : '0;
        pkt_type1   = done && t1_q;
        abort_rdata = (done && route_q[ABORT_IDX] && !wr_q) ? '1 : '0;
        wr_pass     = done && wr_q && !route_q[ABORT_IDX];
        out_bus     = bus_q;
        out_dev     = dev_q;
        out_func    = func_q;
        out_reg     = reg_q;
        out_write   = wr_q;
    end
endmodule

// File: rtl/cfg_route_decoder_chk.sv
module cfg_route_decoder_chk
    import cfg_route_pkg::*;
#(
    parameter int unsigned NUM_LOCAL   = 2,
    parameter int unsigned NUM_BRIDGES = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic                             done,
    input logic [NUM_LOCAL+NUM_BRIDGES+1:0] route,
    input logic                             pkt_type1,
    input logic [DATA_W-1:0]                abort_rdata,
    input logic                             wr_pass,
    input logic                             out_write
);
    localparam int unsigned ABORT_IDX = NUM_LOCAL + NUM_BRIDGES + 1;

    // R2
    route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(route) == 1));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(req_valid));

    // R3
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid) |=> !done);

    // R4
    local_type0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (|route[NUM_LOCAL-1:0])) |-> !pkt_type1);

    // R11
    abort_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && route[ABORT_IDX] && !out_write) |-> (abort_rdata == '1));

    // R11
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pass |-> (done && !route[ABORT_IDX]));
endmodule

bind cfg_route_decoder cfg_route_decoder_chk #(
    .NUM_LOCAL   (NUM_LOCAL),
    .NUM_BRIDGES (NUM_BRIDGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .done        (done),
    .route       (route),
    .pkt_type1   (pkt_type1),
    .abort_rdata (abort_rdata),
    .wr_pass     (wr_pass),
    .out_write   (out_write)
);

// File: tb/tb_cfg_route_decoder.sv
`timescale 1ns/1ps
module tb_cfg_route_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic [1:0]  loc_dev_en = '0;
    logic [31:0] link_dev_present = '0;
    logic [7:0]  link_sec_bus = '0;
    logic [7:0]  link_sub_bus = '0;
    logic [7:0]  bsec0 = '0, bsec1 = '0, bsub0 = '0, bsub1 = '0;
    logic [15:0] br_sec_bus, br_sub_bus;
    logic        done, pkt_type1, wr_pass, out_write;
    logic [5:0]  route;
    logic [31:0] abort_rdata;
    logic [7:0]  out_bus, out_reg;
    logic [4:0]  out_dev;
    logic [2:0]  out_func;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    assign br_sec_bus = {bsec1, bsec0};
    assign br_sub_bus = {bsub1, bsub0};

    always #2 clk = ~clk;

    cfg_route_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_reg(req_reg), .req_write(req_write),
        .loc_dev_en(loc_dev_en), .link_dev_present(link_dev_present),
        .link_sec_bus(link_sec_bus), .link_sub_bus(link_sub_bus),
        .br_sec_bus(br_sec_bus), .br_sub_bus(br_sub_bus),
        .done(done), .route(route), .pkt_type1(pkt_type1),
        .abort_rdata(abort_rdata), .wr_pass(wr_pass),
        .out_bus(out_bus), .out_dev(out_dev), .out_func(out_func),
        .out_reg(out_reg), .out_write(out_write)
    );

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(int b, int lo, int hi);
        return (hi >= lo) && (b >= lo) && (b <= hi);
    endfunction

    // expected route index (0,1 local; 2,3 bridge; 4 link; 5 abort)
    function automatic void model(input int b, input int d, input int f,
                                  output int idx, output bit t1, output string tag);
        bit h0, h1;
        t1 = 1'b0;
        if (b == 0) begin
            if (d < 2 && loc_dev_en[d] && f == 0) begin idx = d; tag = "R4"; end
            else if (link_dev_present[d]) begin idx = 4; tag = "R5"; end
            else begin idx = 5; tag = "R10"; end
        end else begin
            h0 = in_win(b, int'(bsec0), int'(bsub0));
            h1 = in_win(b, int'(bsec1), int'(bsub1));
            if (h0) begin
                idx = 2; t1 = (b != int'(bsec0));
                tag = h1 ? "R7" : "R6";
            end else if (h1) begin
                idx = 3; t1 = (b != int'(bsec1));
                tag = (bsub0 < bsec0 && b >= bsub0 && b <= bsec0) ? "R8" : "R6";
            end else if (in_win(b, int'(link_sec_bus), int'(link_sub_bus))) begin
                idx = 4; t1 = 1'b1; tag = "R9";
            end else begin
                idx = 5;
                tag = ((bsub0 < bsec0 && b >= bsub0 && b <= bsec0) ||
                       (link_sub_bus < link_sec_bus && b >= link_sub_bus && b <= link_sec_bus)) ? "R8" : "R10";
            end
        end
    endfunction

    task automatic do_req(int b, int d, int f, int r, bit wr);
        int ei; bit et1; string tag;
        logic [5:0] ev;
        logic [31:0] efill;
        bit ewp;
        model(b, d, f, ei, et1, tag);
        ev = 6'(1) << ei;
        efill = (ei == 5 && !wr) ? 32'hFFFF_FFFF : 32'h0;
        ewp = wr && (ei != 5);
        @(negedge clk);
        req_bus = 8'(b); req_dev = 5'(d); req_func = 3'(f);
        req_reg = 8'(r); req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R2 and the routing requirement in tag
        chk(done === 1'b1 && route === ev && pkt_type1 === et1, tag,
            {55'd0, done, route, pkt_type1}, {55'd0, 1'b1, ev, et1});
        chk(abort_rdata === efill && wr_pass === ewp, "R11",
            {31'd0, abort_rdata, wr_pass}, {31'd0, efill, ewp});
        chk({out_bus, out_dev, out_func, out_reg, out_write} ===
            {8'(b), 5'(d), 3'(f), 8'(r), wr}, "R12",
            {39'd0, out_bus, out_dev, out_func, out_reg, out_write},
            {39'd0, 8'(b), 5'(d), 3'(f), 8'(r), wr});
    endtask

    task automatic bridge_cfg(int s0, int u0, int s1, int u1, int ls, int lu);
        @(negedge clk);
        bsec0 = 8'(s0); bsub0 = 8'(u0); bsec1 = 8'(s1); bsub1 = 8'(u1);
        link_sec_bus = 8'(ls); link_sub_bus = 8'(lu);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] masks [4];
        masks[0] = 32'hF0F0_0003;
        masks[1] = 32'h0F0F_FFFE;
        masks[2] = 32'h0000_0000;
        masks[3] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done === 1'b0 && route === 6'd0, "R1",
            {57'd0, done, route}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && route === 6'd0, "R1",
            {57'd0, done, route}, 64'd0);

        // bus 0 sweep: R4, R5, R10
        bridge_cfg(1, 4, 5, 9, 10, 255);
        for (int c = 0; c < 4; c++) begin
            loc_dev_en = 2'(c);
            link_dev_present = masks[c];
            for (int d = 0; d < 32; d++)
                for (int f = 0; f < 8; f++)
                    do_req(0, d, f, d * 8 + f, f[0]);
        end

        // bus sweeps: R6 disjoint, R9 link, R10 beyond
        link_dev_present = 32'h0;
        bridge_cfg(1, 4, 5, 9, 10, 200);
        for (int b = 0; b < 256; b++) do_req(b, 3, 0, b ^ 8'h5A, b[0]);
        // R7 overlap
        bridge_cfg(3, 8, 6, 12, 20, 40);
        for (int b = 0; b < 256; b++) do_req(b, 7, 1, b, b[1]);
        // R8 reversed bridge 0
        bridge_cfg(10, 5, 4, 10, 50, 60);
        for (int b = 0; b < 256; b++) do_req(b, 0, 2, 255 - b, b[0]);
        // R8 reversed link, bridge 1 at secondary 0
        bridge_cfg(200, 255, 0, 0, 9, 3);
        for (int b = 0; b < 256; b++) do_req(b, 31, 7, b, !b[0]);

        // R3: request during the decision cycle is dropped
        bridge_cfg(1, 4, 5, 9, 10, 200);
        do_req(2, 1, 0, 8'h11, 1'b0);
        req_bus = 8'd7; req_dev = 5'd9; req_func = 3'd3; req_reg = 8'h77;
        req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done === 1'b0 && route === 6'd0, "R3",
            {57'd0, done, route}, 64'd0);
        @(negedge clk);
        chk(done === 1'b0 && route === 6'd0, "R3",
            {57'd0, done, route}, 64'd0);
        chk(out_bus === 8'd2 && out_reg === 8'h11 && out_write === 1'b0, "R3",
            {47'd0, out_bus, out_reg, out_write}, {47'd0, 8'd2, 8'h11, 1'b0});
        // R2: next request after retirement is accepted normally
        do_req(6, 0, 0, 8'h22, 1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule